// File: doc/BRIEF.md
# Vehicle Drive Mode Controller

This block decides which operating mode an electric-vehicle drive is in. It also decides whether the inverter and the torque command may be active. After reset it holds in a self-test mode until an external checker reports a verdict. A pass leads to an idle mode, and a failure leads straight to a latched fault mode. From idle, the driver's start/key switch moves the drive into run. The same switch then moves it back and forth between run and a halted mode. Any protection flag forces the fault mode at once, from every mode.

The start/key switch and the forward/reverse switch are mechanical contacts. Each passes through a synchronizer and a debounce filter. The filter samples on a shared prescaled tick and accepts a new level only after several agreeing samples. The protection flags, the self-test verdict and the fault clear come from on-chip logic and act without filtering. All pins are plain level signals, because no data stream crosses this block.

Top module: `drive_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, mode is 0 (self-test), `inv_en` and `trq_en` are 0 and `dir_fwd` is 1. Mode codes: 0 self-test, 1 idle, 2 run, 3 halt, 4 fault.
- R2: In self-test, a cycle with `selftest_done` high moves mode to idle on the next clock if `selftest_ok` is high, and to fault if it is low. Without `selftest_done` the mode stays in self-test.
- R3: Idle moves to run only on a low-to-high change of the filtered start signal. A start switch that is already on when idle is entered does not start the drive.
- R4: Run moves to halt when the filtered start is low. Halt moves to run when the filtered start is high.
- R5: Any bit of `fault_flags` high at a clock edge makes mode equal to fault after that edge, whatever the state and whatever other input changes in the same cycle.
- R6: Fault is held until a cycle with `fault_clear` high and all `fault_flags` low, which moves mode to self-test. A clear given while a flag is high is ignored.
- R7: A change on `start_raw` or `dir_raw` is accepted only after it has been seen on HOLD consecutive sample ticks, one tick per TICK_DIV clocks. Shorter pulses leave the mode and `dir_fwd` unchanged.
- R8: `inv_en` is high in exactly the cycles in which mode is run.
- R9: `trq_en` is low in the first run cycle and high in every later consecutive run cycle. It falls in the same cycle as `inv_en`.
- R10: `dir_fwd` takes the filtered direction (1 forward, 0 reverse) on each entry into run and keeps its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_raw | input | 1 | Raw start/key contact, 1 = on |
| dir_raw | input | 1 | Raw direction contact, 1 = forward |
| selftest_done | input | 1 | Self-test verdict is valid this cycle |
| selftest_ok | input | 1 | Self-test verdict, 1 = pass |
| fault_flags | input | NFLT | Protection flags, any bit high = fault |
| fault_clear | input | 1 | Request to leave the fault mode |
| mode | output | 3 | Current mode code |
| inv_en | output | 1 | Inverter enable |
| trq_en | output | 1 | Torque command enable |
| dir_fwd | output | 1 | Direction captured on entry to run |

## Verification
Two functions can meet in one cycle: a mode transition and a fault. The bench provokes this in two ways. First, it pulses a passing self-test verdict in the same cycle as a protection flag. Second, it raises a fault clear while a flag is still high. In both cases the mode after the edge must be fault. Debounce timing is judged only with margins. Pulses are kept well short of the acceptance window, and waits are kept well beyond it. Cycle-exact checks on `inv_en` and `trq_en` are made by polling for the first run cycle.

// File: rtl/drive_mode_pkg.sv
package drive_mode_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_TEST  = 3'd0,
    M_IDLE  = 3'd1,
    M_RUN   = 3'd2,
    M_HALT  = 3'd3,
    M_FAULT = 3'd4
  } drv_mode_e;
endpackage

// File: rtl/sample_tick.sv
module sample_tick #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      logic          tick_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick_o = tick_q;

      a_r7_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
    end else begin : g_every
      assign tick_o = rst_n;
    end
  endgenerate
endmodule

// File: rtl/contact_filter.sv
module contact_filter #(
  parameter int unsigned HOLD = 10,
  parameter logic        INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= INIT;
      s2_q  <= INIT;
      lvl_q <= INIT;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (tick_i) begin
        if (s2_q != lvl_q) begin
          if (cnt_q == HW'(HOLD - 1)) begin
            lvl_q <= s2_q;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign lvl_o = lvl_q;

  a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> $past(tick_i));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import drive_mode_pkg::*;
#(
  parameter int unsigned NFLT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_db_i,
  input  logic            dir_db_i,
  input  logic            st_done_i,
  input  logic            st_ok_i,
  input  logic [NFLT-1:0] flt_i,
  input  logic            clr_i,
  output drv_mode_e       mode_o,
  output logic            inv_en_o,
  output logic            trq_en_o,
  output logic            dir_o
);
  drv_mode_e mode_q, nxt;
  logic      start_q, inv_q, trq_q, dir_q;
  logic      flt_any, start_rise;

  assign flt_any    = |flt_i;
  assign start_rise = start_db_i & ~start_q;

  always_comb begin
    nxt = mode_q;
    unique case (mode_q)
      M_TEST:  if (st_done_i) nxt = st_ok_i ? M_IDLE : M_FAULT;
      M_IDLE:  if (start_rise) nxt = M_RUN;
      M_RUN:   if (!start_db_i) nxt = M_HALT;
      M_HALT:  if (start_db_i) nxt = M_RUN;
      M_FAULT: if (clr_i && !flt_any) nxt = M_TEST;
      default: nxt = M_FAULT;
    endcase
    if (flt_any) nxt = M_FAULT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_TEST;
      start_q <= 1'b0;
      inv_q   <= 1'b0;
      trq_q   <= 1'b0;
      dir_q   <= 1'b1;
    end else begin
      mode_q  <= nxt;
      start_q <= start_db_i;
      inv_q   <= (nxt == M_RUN);
      trq_q   <= (nxt == M_RUN) && (mode_q == M_RUN);
      if (nxt == M_RUN && mode_q != M_RUN) dir_q <= dir_db_i;
    end
  end

  assign mode_o   = mode_q;
  assign inv_en_o = inv_q;
  assign trq_en_o = trq_q;
  assign dir_o    = dir_q;

  a_r5_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flt_any |=> (mode_q == M_FAULT));

  a_r6_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_FAULT && mode_q != M_FAULT)
      |-> (mode_q == M_TEST && $past(clr_i) && !$past(flt_any)));

  a_r2_test_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_TEST && mode_q == M_IDLE) |-> $past(st_done_i && st_ok_i));

  a_r3_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_IDLE && mode_q == M_RUN)
      |-> ($past(start_db_i) && !$past(start_db_i, 2)));

  a_r8_inv_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q == (mode_q == M_RUN));

  a_r9_trq_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
    trq_q |-> (inv_q && $past(inv_q)));

  a_r10_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q == M_RUN && $past(mode_q) != M_RUN) |-> $stable(dir_q));
endmodule

// File: rtl/drive_mode_ctrl.sv
module drive_mode_ctrl
  import drive_mode_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned HOLD     = 10,
  parameter int unsigned NFLT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_raw,
  input  logic              dir_raw,
  input  logic              selftest_done,
  input  logic              selftest_ok,
  input  logic [NFLT-1:0]   fault_flags,
  input  logic              fault_clear,
  output logic [MODE_W-1:0] mode,
  output logic              inv_en,
  output logic              trq_en,
  output logic              dir_fwd
);
  localparam int unsigned NSW      = 2;
  localparam logic [NSW-1:0] SW_INIT = 2'b10;

  logic           tick;
  logic [NSW-1:0] sw_raw, sw_db;
  drv_mode_e      mode_e;

  assign sw_raw = {dir_raw, start_raw};

  sample_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    contact_filter #(.HOLD(HOLD), .INIT(SW_INIT[k])) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .raw_i(sw_raw[k]), .lvl_o(sw_db[k])
    );
  end

  mode_fsm #(.NFLT(NFLT)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_db_i(sw_db[0]), .dir_db_i(sw_db[1]),
    .st_done_i(selftest_done), .st_ok_i(selftest_ok),
    .flt_i(fault_flags), .clr_i(fault_clear),
    .mode_o(mode_e), .inv_en_o(inv_en), .trq_en_o(trq_en), .dir_o(dir_fwd)
  );

  assign mode = mode_e;
endmodule

// File: tb/test_drive_mode_ctrl.sv
module test_drive_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 40;
  localparam int GLITCH = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_raw = 1'b0;
  logic       dir_raw = 1'b1;
  logic       selftest_done = 1'b0;
  logic       selftest_ok = 1'b0;
  logic [3:0] fault_flags = '0;
  logic       fault_clear = 1'b0;
  logic [2:0] mode;
  logic       inv_en, trq_en, dir_fwd;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_mode_ctrl #(.TICK_DIV(4), .HOLD(4), .NFLT(4)) i_drive_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .start_raw(start_raw), .dir_raw(dir_raw),
    .selftest_done(selftest_done), .selftest_ok(selftest_ok),
    .fault_flags(fault_flags), .fault_clear(fault_clear),
    .mode(mode), .inv_en(inv_en), .trq_en(trq_en), .dir_fwd(dir_fwd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input int exp);
    check(int'(mode) == exp, req, int'(mode), exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_mode(input int target, input string req);
    int k = 0;
    while (int'(mode) != target && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk_mode(req, target);
  endtask

  task automatic pulse_done(input logic ok);
    selftest_done = 1'b1;
    selftest_ok = ok;
    @(negedge clk);
    selftest_done = 1'b0;
    selftest_ok = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start_raw = 1'b1;
    wait_cyc(3);
    chk_mode("R1 mode in reset", 0);
    check(inv_en == 1'b0 && trq_en == 1'b0, "R1 enables in reset", {inv_en, trq_en}, 0);
    check(dir_fwd == 1'b1, "R1 dir in reset", dir_fwd, 1);
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    chk_mode("R2 stays in test without verdict", 0);
  endtask

  task automatic t_idle_start;
    pulse_done(1'b1);
    chk_mode("R2 pass goes idle", 1);
    wait_cyc(SETTLE);
    chk_mode("R3 held start does not run", 1);
    start_raw = 1'b0;
    wait_cyc(SETTLE);
    start_raw = 1'b1;
    wait_cyc(GLITCH);
    start_raw = 1'b0;
    wait_cyc(SETTLE);
    chk_mode("R7 short start pulse ignored", 1);
    dir_raw = 1'b0;
    wait_cyc(SETTLE);
    start_raw = 1'b1;
    wait_mode(2, "R3 start edge runs");
    check(inv_en == 1'b1, "R8 inv_en on first run cycle", inv_en, 1);
    check(trq_en == 1'b0, "R9 trq_en low first run cycle", trq_en, 0);
    @(negedge clk);
    check(trq_en == 1'b1, "R9 trq_en high second run cycle", trq_en, 1);
    check(dir_fwd == 1'b0, "R10 reverse captured", dir_fwd, 0);
  endtask

  task automatic t_run_halt;
    dir_raw = 1'b1;
    wait_cyc(SETTLE);
    check(dir_fwd == 1'b0, "R10 dir held during run", dir_fwd, 0);
    start_raw = 1'b0;
    wait_cyc(GLITCH);
    start_raw = 1'b1;
    wait_cyc(SETTLE);
    chk_mode("R7 short stop pulse ignored", 2);
    start_raw = 1'b0;
    wait_mode(3, "R4 run to halt");
    check(inv_en == 1'b0 && trq_en == 1'b0, "R8 R9 enables off in halt", {inv_en, trq_en}, 0);
    start_raw = 1'b1;
    wait_mode(2, "R4 halt to run");
    check(dir_fwd == 1'b1, "R10 forward captured on re-entry", dir_fwd, 1);
  endtask

  task automatic t_fault_latch;
    @(negedge clk);
    fault_flags = 4'b0100;
    @(negedge clk);
    chk_mode("R5 fault from run", 4);
    check(inv_en == 1'b0 && trq_en == 1'b0, "R8 R9 enables drop on fault", {inv_en, trq_en}, 0);
    fault_flags = '0;
    wait_cyc(10);
    chk_mode("R6 fault latched", 4);
    fault_flags = 4'b0001;
    fault_clear = 1'b1;
    @(negedge clk);
    fault_flags = '0;
    fault_clear = 1'b0;
    @(negedge clk);
    chk_mode("R6 clear ignored with flag", 4);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
    chk_mode("R6 clear returns to test", 0);
  endtask

  task automatic t_same_cycle;
    selftest_done = 1'b1;
    selftest_ok = 1'b1;
    fault_flags = 4'b1000;
    @(negedge clk);
    selftest_done = 1'b0;
    selftest_ok = 1'b0;
    fault_flags = '0;
    chk_mode("R5 fault beats self-test pass", 4);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
    chk_mode("R6 back to test", 0);
    pulse_done(1'b0);
    chk_mode("R2 failed self-test faults", 4);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
    pulse_done(1'b1);
    chk_mode("R2 pass to idle again", 1);
    wait_cyc(SETTLE);
    chk_mode("R3 no run without new edge", 1);
  endtask

  initial begin
    wait_cyc(2);
    t_reset();
    t_idle_start();
    t_run_halt();
    t_fault_latch();
    t_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule